// File: doc/BRIEF.md
# Interrupt Pending and Timer Logic

This block sits next to the processor's exception logic and decides, every cycle, whether an interrupt exception should be requested. It keeps the eight-bit interrupt pending vector, in which two bits are set and cleared by software and six bits track hardware interrupt lines. It also owns a free-running cycle counter and a compare value. When the two are equal and the counter is not zero, the block posts a timer interrupt into the pending vector. The pending bit that the timer uses is chosen by a three-bit index input.

The request output is raised when three conditions hold: the global enable is 1, neither the error level nor the exception level is set, and at least one pending bit is also enabled in the eight-bit mask. A separate pending output reports that any bit of the vector is set, whether or not interrupts are enabled. The timer bit stays latched once posted, and only a write of the compare value clears it.

Top module: `irq_ctl`

## Requirements
- R1: While reset is held, and right after it, the outputs read: `ip` = 0, `count` = 0, `compare` = 0, `int_req` = 0, `int_pending` = 0.
- R2: `int_req` is 1 only when `ie` = 1, `erl` = 0 and `exl` = 0; if any of these conditions fails, `int_req` is 0 whatever the pending and mask bits are.
- R3: When enabled, `int_req` = 1 exactly when `im & ip` is nonzero; mask bit i enables pending bit i only.
- R4: A timer hit occurs in a cycle where `compare == count` and `count != 0`. After the next rising edge, bit number `timer_sel` of `ip` reads 1 and the other `ip` bits keep their values.
- R5: A counter value of zero never produces a timer hit, even when `compare` is also zero.
- R6: The latched timer bit stays set across later cycles until a cycle with `cmp_we` = 1. That write clears it at the same edge, and it wins over a hit in the same cycle.
- R7: `count` increases by one at each rising edge and wraps from 0xFFFFFFFF to 0. A cycle with `cnt_we` = 1 loads `cnt_wdata` instead.
- R8: A cycle with `sw_ip_we` = 1 loads `sw_ip_wdata` into `ip[1:0]` at the next edge. Without that write the two bits hold their values.
- R9: Hardware line `hw_irq[k]` is sampled at each edge and appears as `ip[k+2]` after it; the bit clears when the line drops.
- R10: `int_pending` = 1 whenever `ip` is nonzero, regardless of `ie`, `erl`, `exl` and `im`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ie | input | 1 | Global interrupt enable |
| erl | input | 1 | Error level active, blocks requests |
| exl | input | 1 | Exception level active, blocks requests |
| im | input | 8 | Per-bit interrupt mask |
| hw_irq | input | 6 | Hardware interrupt lines, mapped to ip[7:2] |
| sw_ip_we | input | 1 | Write strobe for the software pending bits |
| sw_ip_wdata | input | 2 | New value for ip[1:0] |
| cnt_we | input | 1 | Load strobe for the counter |
| cnt_wdata | input | 32 | Counter load value |
| cmp_we | input | 1 | Compare write strobe, also clears the timer bit |
| cmp_wdata | input | 32 | New compare value |
| timer_sel | input | 3 | Index of the pending bit used by the timer |
| ip | output | 8 | Interrupt pending vector |
| count | output | 32 | Current counter value |
| compare | output | 32 | Current compare value |
| int_pending | output | 1 | Some pending bit is set |
| int_req | output | 1 | Interrupt exception request |

## Verification
The bound checker checks the following on every cycle:
- the request gating by the three enable conditions and by the mask;
- the counter stepping;
- the set, hold and clear rules for the timer latch, including that a zero counter never hits;
- that software and hardware values reach their pending bits after one edge.

Some behaviours need a chosen sequence, so only the bench's scenarios can show them:
- the exact wrap from all ones to zero;
- the cycle where a loaded counter reaches the compare value;
- a compare write that lands in the same cycle as a hit;
- moving the timer index while the latch is set, with the other bits left unchanged.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_CNT_W = 32;
  localparam int IRQ_IP_W  = 8;
  localparam int IRQ_SW_W  = 2;

  typedef struct packed {
    logic ie;
    logic erl;
    logic exl;
  } irq_level_t;
endpackage

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int CNT_W = irq_pkg::IRQ_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] compare,
  output logic             hit,
  output logic             flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic hit_eval(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] m);
    return (c == m) && (c != '0);
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return c + ONE;
  endfunction

  assign hit = hit_eval(count, compare);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cnt_we) begin
      count <= cnt_wdata;
    end else begin
      count <= step(count);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      compare <= '0;
    end else if (cmp_we) begin
      compare <= cmp_wdata;
    end
  end

  // a compare write clears the latch and wins over a hit in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (cmp_we) begin
      flag <= 1'b0;
    end else if (hit) begin
      flag <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_ip_reg.sv
module irq_ip_reg #(
  parameter int IP_W = irq_pkg::IRQ_IP_W,
  parameter int SW_W = irq_pkg::IRQ_SW_W,
  localparam int HW_W  = IP_W - SW_W,
  localparam int SEL_W = $clog2(IP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [SW_W-1:0]  sw_wdata,
  input  logic [HW_W-1:0]  hw_in,
  input  logic             timer_flag,
  input  logic [SEL_W-1:0] timer_sel,
  output logic [IP_W-1:0]  ip
);
  logic [SW_W-1:0] sw_q;
  logic [HW_W-1:0] hw_q;
  logic [IP_W-1:0] base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q <= '0;
    end else if (sw_we) begin
      sw_q <= sw_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_q <= '0;
    end else begin
      hw_q <= hw_in;
    end
  end

  assign base = {hw_q, sw_q};

  // the timer bit is ORed into the selected position, other bits untouched
  for (genvar i = 0; i < IP_W; i++) begin : g_merge
    assign ip[i] = base[i] | (timer_flag && (timer_sel == SEL_W'(i)));
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int IP_W = irq_pkg::IRQ_IP_W
) (
  input  irq_pkg::irq_level_t lvl,
  input  logic [IP_W-1:0]     im,
  input  logic [IP_W-1:0]     ip,
  output logic                req,
  output logic                pending
);
  function automatic logic allowed(input irq_pkg::irq_level_t l);
    return l.ie && !l.erl && !l.exl;
  endfunction

  function automatic logic any_live(input logic [IP_W-1:0] m,
                                    input logic [IP_W-1:0] p);
    return |(m & p);
  endfunction

  assign req     = allowed(lvl) && any_live(im, ip);
  assign pending = |ip;
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int CNT_W = irq_pkg::IRQ_CNT_W,
  parameter int IP_W  = irq_pkg::IRQ_IP_W,
  parameter int SW_W  = irq_pkg::IRQ_SW_W,
  localparam int HW_W  = IP_W - SW_W,
  localparam int SEL_W = $clog2(IP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ie,
  input  logic             erl,
  input  logic             exl,
  input  logic [IP_W-1:0]  im,
  input  logic [HW_W-1:0]  hw_irq,
  input  logic             sw_ip_we,
  input  logic [SW_W-1:0]  sw_ip_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [SEL_W-1:0] timer_sel,
  output logic [IP_W-1:0]  ip,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] compare,
  output logic             int_pending,
  output logic             int_req
);
  // internal events, named for the checker
  logic                timer_hit;
  logic                timer_flag;
  irq_pkg::irq_level_t lvl;

  assign lvl = '{ie: ie, erl: erl, exl: exl};

  irq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .count     (count),
    .compare   (compare),
    .hit       (timer_hit),
    .flag      (timer_flag)
  );

  irq_ip_reg #(.IP_W(IP_W), .SW_W(SW_W)) u_ip (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_we      (sw_ip_we),
    .sw_wdata   (sw_ip_wdata),
    .hw_in      (hw_irq),
    .timer_flag (timer_flag),
    .timer_sel  (timer_sel),
    .ip         (ip)
  );

  irq_gate #(.IP_W(IP_W)) u_gate (
    .lvl     (lvl),
    .im      (im),
    .ip      (ip),
    .req     (int_req),
    .pending (int_pending)
  );
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int CNT_W = 32,
  parameter int IP_W  = 8,
  parameter int SW_W  = 2,
  localparam int HW_W  = IP_W - SW_W,
  localparam int SEL_W = $clog2(IP_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ie,
  input logic             erl,
  input logic             exl,
  input logic [IP_W-1:0]  im,
  input logic [HW_W-1:0]  hw_irq,
  input logic             sw_ip_we,
  input logic [SW_W-1:0]  sw_ip_wdata,
  input logic             cnt_we,
  input logic             cmp_we,
  input logic [SEL_W-1:0] timer_sel,
  input logic [IP_W-1:0]  ip,
  input logic [CNT_W-1:0] count,
  input logic             int_pending,
  input logic             int_req,
  input logic             timer_hit,
  input logic             timer_flag
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_req_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (ie && !erl && !exl));

  p_req_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((im & ip) != '0));

  p_timer_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_hit && !cmp_we) |=> timer_flag);

  p_timer_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timer_flag |-> ip[timer_sel]);

  p_zero_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !timer_hit);

  p_timer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_flag && !cmp_we) |=> timer_flag);

  p_timer_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> !timer_flag);

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(cnt_we)) |-> (count == $past(count) + CNT_W'(1)));

  p_sw_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ip_we |=> ((ip[SW_W-1:0] & $past(sw_ip_wdata)) == $past(sw_ip_wdata)));

  p_hw_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((ip[IP_W-1:SW_W] & $past(hw_irq)) == $past(hw_irq)));

  p_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_pending);
endmodule

bind irq_ctl irq_ctl_chk #(.CNT_W(CNT_W), .IP_W(IP_W), .SW_W(SW_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ie          (ie),
  .erl         (erl),
  .exl         (exl),
  .im          (im),
  .hw_irq      (hw_irq),
  .sw_ip_we    (sw_ip_we),
  .sw_ip_wdata (sw_ip_wdata),
  .cnt_we      (cnt_we),
  .cmp_we      (cmp_we),
  .timer_sel   (timer_sel),
  .ip          (ip),
  .count       (count),
  .int_pending (int_pending),
  .int_req     (int_req),
  .timer_hit   (timer_hit),
  .timer_flag  (timer_flag)
);

// File: tb/irq_ctl_tb_top.sv
module irq_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ie = 1'b0, erl = 1'b0, exl = 1'b0;
  logic [7:0]  im = '0;
  logic [5:0]  hw_irq = '0;
  logic        sw_ip_we = 1'b0;
  logic [1:0]  sw_ip_wdata = '0;
  logic        cnt_we = 1'b0;
  logic [31:0] cnt_wdata = '0;
  logic        cmp_we = 1'b0;
  logic [31:0] cmp_wdata = '0;
  logic [2:0]  timer_sel = '0;
  logic [7:0]  ip;
  logic [31:0] count, compare;
  logic        int_pending, int_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ie(ie), .erl(erl), .exl(exl), .im(im),
    .hw_irq(hw_irq), .sw_ip_we(sw_ip_we), .sw_ip_wdata(sw_ip_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .timer_sel(timer_sel), .ip(ip), .count(count),
    .compare(compare), .int_pending(int_pending), .int_req(int_req)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ip", {24'd0, ip}, 32'd0);
    chk("R1 count", count, 32'd0);
    chk("R1 compare", compare, 32'd0);
    chk("R1 req", {31'd0, int_req}, 32'd0);
    chk("R1 pending", {31'd0, int_pending}, 32'd0);
  endtask

  task automatic t_count_wrap();
    cnt_we = 1'b1; cnt_wdata = 32'hFFFF_FFFE;
    edges(1);
    cnt_we = 1'b0;
    chk("R7 load", count, 32'hFFFF_FFFE);
    edges(1);
    chk("R7 step", count, 32'hFFFF_FFFF);
    edges(1);
    chk("R7 wrap", count, 32'd0);
    // count 0 with compare 0 must not post the timer
    edges(2);
    chk("R5 zero count no hit", {24'd0, ip}, 32'd0);
  endtask

  task automatic t_sw_gate();
    sw_ip_we = 1'b1; sw_ip_wdata = 2'b10;
    edges(1);
    sw_ip_we = 1'b0;
    chk("R8 sw load", {24'd0, ip}, 32'h02);
    edges(2);
    chk("R8 sw hold", {24'd0, ip}, 32'h02);
    chk("R10 pending disabled", {31'd0, int_pending}, 32'd1);
    ie = 1'b1; im = 8'h02; #1;
    chk("R3 req enabled", {31'd0, int_req}, 32'd1);
    erl = 1'b1; #1;
    chk("R2 erl blocks", {31'd0, int_req}, 32'd0);
    erl = 1'b0; exl = 1'b1; #1;
    chk("R2 exl blocks", {31'd0, int_req}, 32'd0);
    exl = 1'b0; ie = 1'b0; #1;
    chk("R2 ie low blocks", {31'd0, int_req}, 32'd0);
    chk("R10 pending kept", {31'd0, int_pending}, 32'd1);
    ie = 1'b1; im = 8'h01; #1;
    chk("R3 mask other bit", {31'd0, int_req}, 32'd0);
    sw_ip_we = 1'b1; sw_ip_wdata = 2'b00;
    edges(1);
    sw_ip_we = 1'b0;
    chk("R8 sw clear", {24'd0, ip}, 32'h00);
  endtask

  task automatic t_hw();
    hw_irq = 6'b000101;
    #1;
    chk("R9 not before edge", {24'd0, ip}, 32'h00);
    edges(1);
    chk("R9 hw follow", {24'd0, ip}, 32'h14);
    im = 8'h10; #1;
    chk("R3 hw req", {31'd0, int_req}, 32'd1);
    hw_irq = 6'b000000;
    edges(1);
    chk("R9 hw drop", {24'd0, ip}, 32'h00);
    chk("R10 idle", {31'd0, int_pending}, 32'd0);
  endtask

  task automatic t_timer();
    sw_ip_we = 1'b1; sw_ip_wdata = 2'b01;
    cmp_we = 1'b1; cmp_wdata = 32'd100;
    cnt_we = 1'b1; cnt_wdata = 32'd97;
    timer_sel = 3'd5;
    edges(1);
    sw_ip_we = 1'b0; cmp_we = 1'b0; cnt_we = 1'b0;
    edges(3);
    chk("R4 count at match", count, 32'd100);
    chk("R4 not yet posted", {24'd0, ip}, 32'h01);
    edges(1);
    chk("R4 timer posted", {24'd0, ip}, 32'h21);
    im = 8'h20; #1;
    chk("R4 timer req", {31'd0, int_req}, 32'd1);
    timer_sel = 3'd2; #1;
    chk("R4 moved index", {24'd0, ip}, 32'h05);
    edges(10);
    chk("R6 latched", {24'd0, ip}, 32'h05);
    cmp_we = 1'b1; cmp_wdata = 32'd50000;
    edges(1);
    cmp_we = 1'b0;
    chk("R6 cleared by write", {24'd0, ip}, 32'h01);
    // write in the same cycle as a hit
    cmp_we = 1'b1; cmp_wdata = 32'd200;
    cnt_we = 1'b1; cnt_wdata = 32'd199;
    edges(1);
    cmp_we = 1'b0; cnt_we = 1'b0;
    edges(1);
    chk("R4 at match again", count, 32'd200);
    cmp_we = 1'b1; cmp_wdata = 32'd300;
    edges(1);
    cmp_we = 1'b0;
    chk("R6 write beats hit", {24'd0, ip}, 32'h01);
    edges(3);
    chk("R6 stays clear", {24'd0, ip}, 32'h01);
  endtask

  initial begin
    edges(3);
    t_reset();
    rst_n = 1'b1;
    edges(1);
    chk("R1 count after release", count, 32'd1);
    t_count_wrap();
    t_sw_gate();
    t_hw();
    t_timer();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule